// File: doc/BRIEF.md
# Calendar Alarm Match, Interrupt and Power-Off Unit

This unit sits next to a BCD calendar counter. It holds two independent alarm sets of six BCD fields each (second, minute, hour, day, month, year). On every once-per-second update strobe it compares the live time against both sets. An alarm fires only on an exact match of all six fields, because no field can be masked. Each firing latches a sticky status flag. Software clears a flag by writing a one to its status bit.

The unit drives three pins from these flags and from a small set of control bits:
- An interrupt line, which is the OR of the enabled pending conditions: the per-second event, alarm A and alarm B.
- A wake line, which carries alarm A when its wake route is enabled.
- A power-enable pin for an external power controller. When power control is armed, an alarm B match drives this pin low. It stays low until reset, which gives a timed system shutdown.

Registers are reached through a simple word-addressed bus with a write strobe and a combinational read-back.

Top module: `rtc_alarm_top`

## Requirements
- R1: Alarm A (fields at 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 = second, minute, hour, day, month, year, each in wdata[7:0]) sets status bit 6 on a strobe only when all six fields equal `now_bcd` (second in bits 7:0, minute 15:8, hour 23:16, day 31:24, month 39:32, year 47:40). A difference in any single field sets nothing.
- R2: Alarm B (same field order at 0x80 to 0x94) sets status bit 7 on a strobe with an exact six-field match.
- R3: Comparison happens only on a cycle with `sec_tick` high. An equal time without the strobe leaves the flags unchanged.
- R4: The status register at 0x44 has sticky bits 2, 6 and 7, cleared by writing 1 to the bit. Writing 0 leaves a bit alone. A set and a clear in the same cycle leave the bit set.
- R5: Every strobe sets status bit 2, the per-second event flag.
- R6: `irq` is high exactly when some pending flag has its enable set in the register at 0x48 (bit 2 per-second, bit 3 alarm A, bit 4 alarm B).
- R7: `wake` is high exactly when bit 1 of the register at 0x7C is set and status bit 6 is pending.
- R8: `pwr_en` is high after reset. A strobe with an alarm B match while bit 16 of the register at 0x98 is set drives it low, and it stays low until reset, even if the flag is cleared. Without bit 16, alarm B leaves it high.
- R9: Every alarm field and control register reads back on `rdata` in the same cycle the address is presented. Unmapped addresses read zero.
- R10: Reset clears all flags, enables and alarm fields, with `irq` and `wake` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_bcd | input | 48 | Live BCD time, six 8-bit fields |
| sec_tick | input | 1 | One-cycle once-per-second update strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Timer/alarm interrupt |
| wake | output | 1 | Alarm A wake request |
| pwr_en | output | 1 | External power enable, high = on |

## Verification
A flag can be set by a strobe match in the same cycle that software writes one to clear it. The bench provokes this by driving a matching time with `sec_tick` and a status write of bit 6 on the same clock edge. It judges the result by reading status afterward: bit 6 must still be set, and `irq` must follow it. A second collision checks that alarms A and B both match on one strobe and set both flags.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;
    localparam int TIME_W     = FIELD_W * NUM_FIELDS;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int NUM_SETS   = 2;

    localparam logic [ADDR_W-1:0] SET_A_BASE = 8'h20;
    localparam logic [ADDR_W-1:0] SET_B_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] STAT_ADDR  = 8'h44;
    localparam logic [ADDR_W-1:0] IEN_ADDR   = 8'h48;
    localparam logic [ADDR_W-1:0] WAKE_ADDR  = 8'h7C;
    localparam logic [ADDR_W-1:0] PWR_ADDR   = 8'h98;

    localparam int ST_SEC_BIT  = 2;
    localparam int ST_A_BIT    = 6;
    localparam int ST_B_BIT    = 7;
    localparam int IE_SEC_BIT  = 2;
    localparam int IE_A_BIT    = 3;
    localparam int IE_B_BIT    = 4;
    localparam int WAKE_A_BIT  = 1;
    localparam int PWR_ARM_BIT = 16;

    typedef struct packed {
        logic       flag_sec;
        logic       flag_a;
        logic       flag_b;
        logic       ie_sec;
        logic       ie_a;
        logic       ie_b;
        logic       wake_a;
        logic       pwr_arm;
        logic       pwr_off;
    } ctl_state_t;
endpackage

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank #(
    parameter int                FW   = 8,
    parameter int                NF   = 6,
    parameter int                AW   = 8,
    parameter logic [AW-1:0]     BASE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [FW-1:0]    wdata,
    input  logic [NF*FW-1:0] now,
    input  logic             tick,
    output logic             match,
    output logic [FW-1:0]    rd_data
);
    localparam int STRIDE = 4;

    logic [NF-1:0][FW-1:0] fld_d, fld_q;
    logic [NF-1:0]         sel;
    logic [NF-1:0]         eq;
    logic [AW-1:0]         off;

    assign off = addr - BASE;

    for (genvar k = 0; k < NF; k++) begin : g_field
        assign sel[k] = (off == AW'(STRIDE * k));
        assign eq[k]  = (now[k*FW +: FW] == fld_q[k]);
    end

    always_comb begin
        fld_d   = fld_q;
        rd_data = '0;
        for (int k = 0; k < NF; k++) begin
            if (wr_en && sel[k]) fld_d[k] = wdata;
            if (sel[k])          rd_data  = fld_q[k];
        end
    end

    assign match = tick && (&eq);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
    end
endmodule

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl
    import rtc_alarm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    input  logic          hit_a,
    input  logic          hit_b,
    output logic          irq,
    output logic          wake,
    output logic          pwr_en,
    output logic          flag_a,
    output logic          flag_b,
    output logic [2:0]    ien,
    output logic [DW-1:0] rd_data
);
    ctl_state_t st_d, st_q;

    logic wr_stat, wr_ien, wr_wake, wr_pwr;

    assign wr_stat = wr_en && (addr == AW'(STAT_ADDR));
    assign wr_ien  = wr_en && (addr == AW'(IEN_ADDR));
    assign wr_wake = wr_en && (addr == AW'(WAKE_ADDR));
    assign wr_pwr  = wr_en && (addr == AW'(PWR_ADDR));

    always_comb begin
        st_d = st_q;
        // clear first, then set, so a same-cycle event wins
        if (wr_stat) begin
            if (wdata[ST_SEC_BIT]) st_d.flag_sec = 1'b0;
            if (wdata[ST_A_BIT])   st_d.flag_a   = 1'b0;
            if (wdata[ST_B_BIT])   st_d.flag_b   = 1'b0;
        end
        if (tick)  st_d.flag_sec = 1'b1;
        if (hit_a) st_d.flag_a   = 1'b1;
        if (hit_b) st_d.flag_b   = 1'b1;
        if (wr_ien) begin
            st_d.ie_sec = wdata[IE_SEC_BIT];
            st_d.ie_a   = wdata[IE_A_BIT];
            st_d.ie_b   = wdata[IE_B_BIT];
        end
        if (wr_wake) st_d.wake_a  = wdata[WAKE_A_BIT];
        if (wr_pwr)  st_d.pwr_arm = wdata[PWR_ARM_BIT];
        if (hit_b && st_q.pwr_arm) st_d.pwr_off = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr == AW'(STAT_ADDR)) begin
            rd_data[ST_SEC_BIT] = st_q.flag_sec;
            rd_data[ST_A_BIT]   = st_q.flag_a;
            rd_data[ST_B_BIT]   = st_q.flag_b;
        end else if (addr == AW'(IEN_ADDR)) begin
            rd_data[IE_SEC_BIT] = st_q.ie_sec;
            rd_data[IE_A_BIT]   = st_q.ie_a;
            rd_data[IE_B_BIT]   = st_q.ie_b;
        end else if (addr == AW'(WAKE_ADDR)) begin
            rd_data[WAKE_A_BIT] = st_q.wake_a;
        end else if (addr == AW'(PWR_ADDR)) begin
            rd_data[PWR_ARM_BIT] = st_q.pwr_arm;
        end
    end

    assign irq    = (st_q.flag_sec && st_q.ie_sec) ||
                    (st_q.flag_a   && st_q.ie_a)   ||
                    (st_q.flag_b   && st_q.ie_b);
    assign wake   = st_q.flag_a && st_q.wake_a;
    assign pwr_en = !st_q.pwr_off;
    assign flag_a = st_q.flag_a;
    assign flag_b = st_q.flag_b;
    assign ien    = {st_q.ie_b, st_q.ie_a, st_q.ie_sec};
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_alarm_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int NF = NUM_FIELDS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NF*FW-1:0] now_bcd,
    input  logic             sec_tick,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq,
    output logic             wake,
    output logic             pwr_en
);
    localparam logic [NUM_SETS-1:0][AW-1:0] SET_BASES = {AW'(SET_B_BASE), AW'(SET_A_BASE)};

    logic [NUM_SETS-1:0]         set_hit;
    logic [NUM_SETS-1:0][FW-1:0] set_rd;
    logic [DW-1:0]               ctl_rd;
    logic [FW-1:0]               fld_rd;
    logic                        flag_a, flag_b;
    logic [2:0]                  ien;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        rtc_alarm_bank #(
            .FW(FW), .NF(NF), .AW(AW), .BASE(SET_BASES[s])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we),
            .addr    (bus_addr),
            .wdata   (bus_wdata[FW-1:0]),
            .now     (now_bcd),
            .tick    (sec_tick),
            .match   (set_hit[s]),
            .rd_data (set_rd[s])
        );
    end

    rtc_alarm_ctl #(.AW(AW), .DW(DW)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .tick    (sec_tick),
        .hit_a   (set_hit[0]),
        .hit_b   (set_hit[1]),
        .irq     (irq),
        .wake    (wake),
        .pwr_en  (pwr_en),
        .flag_a  (flag_a),
        .flag_b  (flag_b),
        .ien     (ien),
        .rd_data (ctl_rd)
    );

    always_comb begin
        fld_rd = '0;
        for (int s = 0; s < NUM_SETS; s++) fld_rd = fld_rd | set_rd[s];
    end

    assign bus_rdata = ctl_rd | DW'(fld_rd);
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       irq,
    input logic       wake,
    input logic       pwr_en,
    input logic       flag_a,
    input logic       flag_b,
    input logic [2:0] ien
);
    AST_FLAG_A_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> $past(sec_tick)); // R3
    AST_FLAG_B_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_b) |-> $past(sec_tick)); // R2
    AST_PWR_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !pwr_en); // R8
    AST_PWR_OFF_BY_B: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> flag_b); // R8
    AST_WAKE_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> flag_a); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 3'b000) |-> !irq); // R6
endmodule

bind rtc_alarm_top rtc_alarm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .irq      (irq),
    .wake     (wake),
    .pwr_en   (pwr_en),
    .flag_a   (flag_a),
    .flag_b   (flag_b),
    .ien      (ien)
);

// File: tb/sim_rtc_alarm_top.sv
`timescale 1ns/1ps
module sim_rtc_alarm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] now_bcd = '0;
    logic        sec_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake, pwr_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // field order: year, month, day, hour, minute, second (second in low byte)
    localparam logic [47:0] T_A = 48'h24_06_15_13_45_30;
    localparam logic [47:0] T_B = 48'h25_12_31_23_59_58;
    localparam logic [47:0] T_X = 48'h30_01_01_00_00_01;

    always #2.5 clk = ~clk;

    rtc_alarm_top u0 (
        .clk(clk), .rst_n(rst_n), .now_bcd(now_bcd), .sec_tick(sec_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wake(wake), .pwr_en(pwr_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick_at(input logic [47:0] t);
        @(negedge clk);
        now_bcd = t; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic prog_set(input logic [7:0] base, input logic [47:0] t);
        for (int k = 0; k < 6; k++) wr(base + 8'(4 * k), {24'h0, t[8*k +: 8]});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R10", "irq after reset", {31'b0, irq}, 0);
        chk("R10", "wake after reset", {31'b0, wake}, 0);
        chk("R8", "pwr_en after reset", {31'b0, pwr_en}, 1);
        rd(8'h44, v); chk("R10", "status after reset", v, 0);
        rd(8'h28, v); chk("R10", "alarm field after reset", v, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        prog_set(8'h20, T_A);
        for (int k = 0; k < 6; k++) begin
            rd(8'h20 + 8'(4 * k), v);
            chk("R9", "alarm A field readback", v, {24'h0, T_A[8*k +: 8]});
        end
        prog_set(8'h80, T_B);
        rd(8'h8C, v); chk("R9", "alarm B day readback", v, {24'h0, T_B[31:24]});
        rd(8'h60, v); chk("R9", "unmapped reads zero", v, 0);
        rd(8'h22, v); chk("R9", "misaligned reads zero", v, 0);
    endtask

    task automatic t_alarm_a();
        logic [31:0] v;
        // equal time without the strobe
        @(negedge clk); now_bcd = T_A;
        repeat (3) @(negedge clk);
        rd(8'h44, v); chk("R3", "no flag without strobe", v, 0);
        tick_at({T_A[47:40] + 8'h01, T_A[39:0]});
        rd(8'h44, v); chk("R1", "year differs no flag", v & 32'h40, 0);
        chk("R5", "second flag on strobe", v & 32'h4, 32'h4);
        tick_at({T_A[47:16], 8'h46, T_A[7:0]});
        rd(8'h44, v); chk("R1", "minute differs no flag", v & 32'h40, 0);
        tick_at(T_A);
        rd(8'h44, v); chk("R1", "exact match sets bit6", v & 32'h40, 32'h40);
        chk("R6", "irq low with no enables", {31'b0, irq}, 0);
        wr(8'h48, 32'h08);
        rd(8'h48, v); chk("R9", "enable readback", v, 32'h08);
        chk("R6", "irq from alarm A", {31'b0, irq}, 1);
        chk("R7", "wake low without route", {31'b0, wake}, 0);
        wr(8'h7C, 32'h2);
        #1 chk("R7", "wake with route", {31'b0, wake}, 1);
        wr(8'h44, 32'h0);
        rd(8'h44, v); chk("R4", "write 0 keeps bit6", v & 32'h40, 32'h40);
        wr(8'h44, 32'h40);
        rd(8'h44, v); chk("R4", "W1C clears bit6", v & 32'h40, 0);
        chk("R4", "bit2 untouched by bit6 clear", v & 32'h4, 32'h4);
        chk("R6", "irq drops after clear", {31'b0, irq}, 0);
        chk("R7", "wake drops after clear", {31'b0, wake}, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(8'h44, 32'hC4);
        wr(8'h48, 32'h04);
        #1 chk("R6", "irq low before event", {31'b0, irq}, 0);
        tick_at(T_X);
        #1 chk("R5", "periodic irq after strobe", {31'b0, irq}, 1);
        wr(8'h44, 32'h04);
        rd(8'h44, v); chk("R4", "periodic flag cleared", v, 0);
        chk("R6", "irq low after periodic clear", {31'b0, irq}, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(8'h48, 32'h08);
        @(negedge clk);
        now_bcd = T_A; sec_tick = 1'b1;
        bus_we = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h40;
        @(negedge clk);
        sec_tick = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        rd(8'h44, v); chk("R4", "set wins over same-cycle clear", v & 32'h40, 32'h40);
        chk("R6", "irq follows surviving flag", {31'b0, irq}, 1);
        wr(8'h44, 32'hC4);
        prog_set(8'h80, T_A);
        tick_at(T_A);
        rd(8'h44, v); chk("R2", "both alarms on one strobe", v & 32'hC0, 32'hC0);
        wr(8'h44, 32'hC4);
        prog_set(8'h80, T_B);
    endtask

    task automatic t_alarm_b();
        logic [31:0] v;
        wr(8'h48, 32'h00);
        tick_at({T_B[47:8], 8'h57});
        rd(8'h44, v); chk("R2", "second differs no bit7", v & 32'h80, 0);
        tick_at(T_B);
        rd(8'h44, v); chk("R2", "alarm B sets bit7", v & 32'hC0, 32'h80);
        chk("R8", "pwr_en high when unarmed", {31'b0, pwr_en}, 1);
        wr(8'h44, 32'hC4);
    endtask

    task automatic t_pmic();
        logic [31:0] v;
        wr(8'h98, 32'h0001_0000);
        rd(8'h98, v); chk("R9", "power arm readback", v, 32'h0001_0000);
        tick_at(T_A);
        chk("R8", "pwr_en high on A match", {31'b0, pwr_en}, 1);
        wr(8'h48, 32'h10);
        tick_at(T_B);
        chk("R8", "pwr_en low after armed B", {31'b0, pwr_en}, 0);
        chk("R6", "irq from alarm B", {31'b0, irq}, 1);
        wr(8'h44, 32'hC4);
        wr(8'h98, 32'h0);
        tick_at(T_X);
        chk("R8", "pwr_en stays low", {31'b0, pwr_en}, 0);
        chk("R6", "irq low after B clear", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_alarm_a();
        t_periodic();
        t_collide();
        t_alarm_b();
        t_pmic();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule